// File: doc/BRIEF.md
# Basketball game and shot clock

This block keeps time for a basketball scoreboard. It holds two countdowns in packed BCD, both running from one system clock. The shot clock starts at 24.00 and counts down in hundredths of a second. The period clock starts at 12:00 and counts down in whole seconds. Two internal prescalers produce single-cycle tick enables that set the pace. No divided clocks are used.

One pause input freezes both countdowns and both prescalers. A period restart reloads both clocks. A possession restart reloads only the shot clock. When a clock reaches zero it holds there and raises its expiry flag. When the period clock expires, the shot clock stops as well. The four-digit outputs go straight to a display multiplexer outside this block.

Top module: `game_clock_unit`

## Requirements
- R1: While rst_ni is low, and right after it is released, the shot output is 16'h2400, the period output is 16'h1200 and both expiry flags are 0.
- R2: The shot clock drops by 0.01 s once every FAST_DIV unpaused cycles. Its nibbles are, from bit 15 down, seconds tens, seconds units, tenths and hundredths. Every digit borrows in decimal, so 16'h2400 is followed by 16'h2399 and 16'h2000 by 16'h1999.
- R3: The period clock drops by 1 s once every SLOW_DIV unpaused cycles. Its nibbles are, from bit 15 down, minutes tens, minutes units, seconds tens and seconds units. The seconds-tens digit borrows in base 6, so 16'h1200 is followed by 16'h1159 and 16'h1000 by 16'h0959.
- R4: While pause_i is high and neither restart is asserted, both outputs stay unchanged. The prescaler phase is also held, so counting resumes exactly where it stopped.
- R5: A period_restart_i cycle loads 16'h2400 and 16'h1200 on the next edge and clears both prescalers. It wins over possession_restart_i when both are high.
- R6: A possession_restart_i cycle without a period restart loads the shot clock with 16'h2400 and clears its prescaler. The period clock keeps counting, or stays frozen, exactly as if no restart had happened.
- R7: Once the shot clock reaches 16'h0000 it stays there with shot_expired_o high until it is reloaded. It never wraps.
- R8: Once the period clock reaches 16'h0000 it stays there with period_expired_o high until a period restart. While the period clock is expired the shot clock does not count, although a possession restart still reloads it.
- R9: Every nibble of both outputs is at most 9. The period seconds-tens nibble is at most 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low, loads the start values |
| pause_i | input | 1 | Freezes both clocks and both prescalers |
| period_restart_i | input | 1 | Reloads both clocks synchronously |
| possession_restart_i | input | 1 | Reloads the shot clock only |
| shot_bcd_o | output | 16 | Shot clock, four BCD digits SS.hh |
| period_bcd_o | output | 16 | Period clock, four BCD digits MM:SS |
| shot_expired_o | output | 1 | Shot clock is at zero |
| period_expired_o | output | 1 | Period clock is at zero |

## Verification
Period expiry is the hardest state to reach from the ports. Once it is reached, the shot clock must freeze even though its own prescaler keeps running. With real divisors it would take millions of cycles to get there. The bench therefore uses tiny divisors, so both countdowns can be swept through every value. It runs the shot clock to zero and issues a possession restart, then lets the period clock expire and issues another possession restart. After that second restart the shot clock must reload and then stay at 24.00. Every cycle is compared against an integer model of the remaining time, converted to BCD arithmetically.

// File: rtl/gcu_pkg.sv
package gcu_pkg;
  typedef logic [15:0] bcd4_t;

  localparam bcd4_t SHOT_START   = 16'h2400;
  localparam bcd4_t SHOT_MAX     = 16'h9999;
  localparam bcd4_t PERIOD_START = 16'h1200;
  // seconds-tens digit borrows in base 6
  localparam bcd4_t PERIOD_MAX   = 16'h9959;
endpackage

// File: rtl/gcu_prescaler.sv
module gcu_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gcu_bcd_down.sv
module gcu_bcd_down
  import gcu_pkg::*;
#(
  parameter int unsigned NDIG  = 4,
  parameter bcd4_t       START = SHOT_START,
  parameter bcd4_t       DMAX  = SHOT_MAX
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output bcd4_t val_o,
  output logic  zero_o
);
  logic [NDIG-1:0][3:0] dig_q, dig_d;
  logic [NDIG:0]        low_zero;
  logic                 all_zero;
  logic                 zero_q;

  assign low_zero[0] = 1'b1;
  assign all_zero    = low_zero[NDIG];

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    localparam logic [3:0] MAXV = DMAX[4*i +: 4];
    assign low_zero[i+1] = low_zero[i] && (dig_q[i] == 4'd0);
    always_comb begin
      dig_d[i] = dig_q[i];
      if (low_zero[i]) dig_d[i] = (dig_q[i] == 4'd0) ? MAXV : dig_q[i] - 4'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dig_q  <= START;
      zero_q <= 1'b0;
    end else if (load_i) begin
      dig_q  <= START;
      zero_q <= (START == '0);
    end else if (step_i && !all_zero) begin
      dig_q  <= dig_d;
      zero_q <= (dig_d == '0);
    end
  end

  assign val_o  = dig_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/game_clock_unit.sv
module game_clock_unit
  import gcu_pkg::*;
#(
  parameter int unsigned FAST_DIV = 500_000,
  parameter int unsigned SLOW_DIV = 50_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pause_i,
  input  logic        period_restart_i,
  input  logic        possession_restart_i,
  output logic [15:0] shot_bcd_o,
  output logic [15:0] period_bcd_o,
  output logic        shot_expired_o,
  output logic        period_expired_o
);
  logic fast_tick, slow_tick;
  logic shot_load;

  assign shot_load = period_restart_i || possession_restart_i;

  gcu_prescaler #(.DIV(FAST_DIV)) u_fast (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(shot_load),
    .run_i (!pause_i), .tick_o(fast_tick)
  );

  gcu_prescaler #(.DIV(SLOW_DIV)) u_slow (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(period_restart_i),
    .run_i (!pause_i), .tick_o(slow_tick)
  );

  gcu_bcd_down #(.NDIG(4), .START(SHOT_START), .DMAX(SHOT_MAX)) u_shot (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(shot_load),
    .step_i(fast_tick && !period_expired_o),
    .val_o (shot_bcd_o), .zero_o(shot_expired_o)
  );

  gcu_bcd_down #(.NDIG(4), .START(PERIOD_START), .DMAX(PERIOD_MAX)) u_period (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(period_restart_i),
    .step_i(slow_tick),
    .val_o (period_bcd_o), .zero_o(period_expired_o)
  );
endmodule

// File: rtl/gcu_checker.sv
module gcu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pause_i,
  input logic        period_restart_i,
  input logic        possession_restart_i,
  input logic [15:0] shot_bcd_o,
  input logic [15:0] period_bcd_o,
  input logic        shot_expired_o,
  input logic        period_expired_o
);
  // R4
  pause_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i && !period_restart_i && !possession_restart_i
    |=> $stable(shot_bcd_o) && $stable(period_bcd_o));

  // R5
  period_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_restart_i |=> shot_bcd_o == 16'h2400 && period_bcd_o == 16'h1200
                         && !shot_expired_o && !period_expired_o);

  // R6
  possession_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    possession_restart_i && !period_restart_i |=> shot_bcd_o == 16'h2400);

  // R6
  possession_keeps_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    possession_restart_i && !period_restart_i && pause_i |=> $stable(period_bcd_o));

  // R7
  shot_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shot_expired_o && !period_restart_i && !possession_restart_i
    |=> shot_expired_o && shot_bcd_o == 16'h0000);

  // R8
  period_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_expired_o && !period_restart_i
    |=> period_expired_o && period_bcd_o == 16'h0000);

  // R8
  shot_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_expired_o && !period_restart_i && !possession_restart_i
    |=> $stable(shot_bcd_o));

  // R9
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shot_bcd_o[15:12] <= 4'd9 && shot_bcd_o[11:8] <= 4'd9 &&
    shot_bcd_o[7:4] <= 4'd9 && shot_bcd_o[3:0] <= 4'd9 &&
    period_bcd_o[15:12] <= 4'd9 && period_bcd_o[11:8] <= 4'd9 &&
    period_bcd_o[7:4] <= 4'd5 && period_bcd_o[3:0] <= 4'd9);
endmodule

bind game_clock_unit gcu_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .pause_i(pause_i),
  .period_restart_i(period_restart_i), .possession_restart_i(possession_restart_i),
  .shot_bcd_o(shot_bcd_o), .period_bcd_o(period_bcd_o),
  .shot_expired_o(shot_expired_o), .period_expired_o(period_expired_o)
);

// File: tb/game_clock_unit_tb.sv
`timescale 1ns/1ps
module game_clock_unit_tb_top;
  localparam int F = 2;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pause = 1'b0, prst = 1'b0, hrst = 1'b0;
  logic [15:0] shot, per;
  logic shot_x, per_x;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  game_clock_unit #(.FAST_DIV(F), .SLOW_DIV(S)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pause_i(pause),
    .period_restart_i(prst), .possession_restart_i(hrst),
    .shot_bcd_o(shot), .period_bcd_o(per),
    .shot_expired_o(shot_x), .period_expired_o(per_x)
  );

  // integer model: remaining hundredths / seconds, prescaler phases
  int m_shot, m_per, m_fc, m_sc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_shot <= 2400; m_per <= 720; m_fc <= 0; m_sc <= 0;
    end else if (prst) begin
      m_shot <= 2400; m_per <= 720; m_fc <= 0; m_sc <= 0;
    end else begin
      if (hrst) begin
        m_shot <= 2400; m_fc <= 0;
      end else if (!pause) begin
        if (m_fc == F-1) begin
          m_fc <= 0;
          if (m_shot > 0 && m_per > 0) m_shot <= m_shot - 1;
        end else m_fc <= m_fc + 1;
      end
      if (!pause) begin
        if (m_sc == S-1) begin
          m_sc <= 0;
          if (m_per > 0) m_per <= m_per - 1;
        end else m_sc <= m_sc + 1;
      end
    end
  end

  function automatic logic [15:0] shot_enc(int v);
    return {4'(v/1000), 4'((v/100)%10), 4'((v/10)%10), 4'(v%10)};
  endfunction

  function automatic logic [15:0] per_enc(int v);
    int m = v / 60, s = v % 60;
    return {4'(m/10), 4'(m%10), 4'(s/10), 4'(s%10)};
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] es, ep;
      es = shot_enc(m_shot);
      ep = per_enc(m_per);
      n_chk++;
      if (shot !== es || per !== ep || shot_x !== (m_shot == 0) || per_x !== (m_per == 0)) begin
        n_bad++;
        $display("FAIL %s cyc %0d: shot %h/%b per %h/%b, expected %h/%b %h/%b",
                 tag, cyc, shot, shot_x, per, per_x, es, m_shot == 0, ep, m_per == 0);
      end
      n_chk++;
      if (shot[15:12] > 9 || shot[11:8] > 9 || shot[7:4] > 9 || shot[3:0] > 9 ||
          per[15:12] > 9 || per[11:8] > 9 || per[7:4] > 5 || per[3:0] > 9) begin
        n_bad++;
        $display("FAIL R9 cyc %0d: shot %h per %h, expected valid BCD digits", cyc, shot, per);
      end
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: cycle %0d, expected end of stimulus", cyc);
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    wait_cyc(5);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(3);
    // R2 R3: free counting, borrows 2400->2399, 1200->1159
    tag = "R2_R3";
    wait_cyc(400);
    // R4: irregular pause pattern
    tag = "R4";
    for (int i = 0; i < 300; i++) begin
      pause = ((i % 7) < 3) || ((i % 13) == 5);
      @(negedge clk);
    end
    pause = 1'b1; wait_cyc(50); pause = 1'b0;
    // R6: possession restarts, one while paused
    tag = "R6";
    for (int k = 0; k < 6; k++) begin
      wait_cyc(150 + 37 * k);
      pause = (k == 3);
      hrst = 1'b1; @(negedge clk); hrst = 1'b0;
      wait_cyc(5); pause = 1'b0;
    end
    // R5: both restarts together, and alone
    tag = "R5";
    prst = 1'b1; hrst = 1'b1; @(negedge clk); prst = 1'b0; hrst = 1'b0;
    wait_cyc(101);
    pause = 1'b1; prst = 1'b1; @(negedge clk); prst = 1'b0; wait_cyc(3); pause = 1'b0;
    // R7: run shot clock to zero and hold
    tag = "R7";
    wait_cyc(2400 * F + 200);
    hrst = 1'b1; @(negedge clk); hrst = 1'b0;
    // R8: period expiry freezes shot clock
    tag = "R8";
    wait_cyc(720 * S);
    hrst = 1'b1; @(negedge clk); hrst = 1'b0;
    wait_cyc(200);
    tag = "R5";
    prst = 1'b1; @(negedge clk); prst = 1'b0;
    wait_cyc(300);
    finish_run();
  end
endmodule